// File: doc/BRIEF.md
# Edge-Selectable Pin Interrupt Controller

This block turns eight general-purpose input pins into external interrupt sources. Each pin first passes through a two-stage synchronizer. The synchronized level is then XORed with a per-pin polarity bit, and a low-to-high step of that adjusted level counts as an edge. An edge sets the pin's flag bit, whether or not the pin is enabled.

A per-pin enable byte masks the flags. The masked flags are ORed into one registered interrupt request. Because detection works on the adjusted level, changing a polarity bit while the pin is steady can itself produce an edge. Software should therefore clear the flags after programming the polarity, and only then set the enables.

Software reaches three byte-wide registers through a small synchronous bus. The bus has an address, a write strobe, write data and combinational read data. Writes take effect at the rising clock edge on which the strobe is sampled.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset, the polarity, flag and enable registers all read 0x00, and `irq_o` is low.
- R2: The register map is: address 0x017 is the polarity register, 0x018 is the flag register, and 0x019 is the enable register. `bus_rdata` shows the addressed register in the same cycle. A write with `bus_we` high updates the register at the next rising edge.
- R3: Polarity bit value 0 selects the rising edge of that pin, and value 1 selects the falling edge. After a pin changes, its flag is set at the third rising edge: two synchronizer stages, then the edge and flag update. Several pins that change together all set their flags together.
- R4: A flag is set by an edge of the selected type even when that pin's enable bit is 0.
- R5: A polarity write that turns (pin XOR polarity) from 0 to 1 on a steady pin sets that pin's flag one edge after the write takes effect. A polarity write that turns it from 1 to 0 sets no flag.
- R6: A write to the flag register loads the written byte, so writing 0 to a bit clears it. Without such a write, a set flag stays set.
- R7: If an edge is detected in the same cycle as a write of 0 to its flag bit, the flag stays set.
- R8: `irq_o` is registered. It goes high one rising edge after some flag and its enable are both 1. It goes low one rising edge after no enabled flag remains. A flag whose enable is 0 never raises it.
- R9: Addresses other than the three mapped ones read as 0x00, and writes to them change no register.
- R10: An edge of the unselected type sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_i | input | 8 | Asynchronous pin levels |
| bus_addr | input | 9 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Each result is due at a known edge:
- A pin change shows up in the flag register after three rising edges.
- A polarity write that creates an edge shows up one edge after the write lands.
- A register write is readable right after the edge that samples it.
- The request follows a flag or enable change by one further edge.

The driver queues each expected value in the cycle it is due, sometimes also one cycle before, when the old value must still hold. The monitor compares the queued value against the outputs a little after the following falling edge, so a result that comes early or late is reported as a mismatch.

// File: rtl/pin_edge_irq_pkg.sv
// Shared types for the pin edge interrupt controller.
package pin_edge_irq_pkg;

    // Which register a bus address selects.
    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_POL  = 2'd1,
        RSEL_FLG  = 2'd2,
        RSEL_ENA  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/pei_sync.sv
// Two-stage synchronizer, one per pin.
// Assumes pins are asynchronous to clk. Resets to all zero.
module pei_sync #(
    parameter int unsigned NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] lvl_o
);

    genvar gi;
    generate
        for (gi = 0; gi < NPINS; gi++) begin : g_pin
            logic meta_q;
            logic stab_q;

            // Clock the pin through two flops.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    stab_q <= 1'b0;
                end else begin
                    meta_q <= pin_i[gi];
                    stab_q <= meta_q;
                end
            end

            assign lvl_o[gi] = stab_q;
        end
    endgenerate

endmodule

// File: rtl/pei_edge.sv
// Polarity-adjusted edge detector.
// Adjusted level = synchronized level XOR polarity bit.
// An edge is a 0->1 step of the adjusted level, so a polarity change on a
// steady pin may also count. The edge output is combinational and lasts one cycle.
module pei_edge #(
    parameter int unsigned NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] lvl_i,
    input  logic [NPINS-1:0] pol_i,
    output logic [NPINS-1:0] edge_o
);

    logic [NPINS-1:0] adj;
    logic [NPINS-1:0] prev_q;

    // Fold the polarity into the level.
    always_comb adj = lvl_i ^ pol_i;

    // Remember the adjusted level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= adj;
    end

    // An edge is the adjusted level now high and previously low.
    always_comb edge_o = adj & ~prev_q;

endmodule

// File: rtl/pei_regs.sv
// Register file and request generator.
// Holds the polarity, flag and enable bytes and decodes the bus.
// Edges OR into the flags after any flag write, so an edge wins over a clear.
// Read data is combinational. The request is registered.
module pei_regs
    import pin_edge_irq_pkg::*;
#(
    parameter int unsigned NPINS = 8,
    parameter int unsigned AW    = 9,
    parameter int unsigned A_POL = 'h17,
    parameter int unsigned A_FLG = 'h18,
    parameter int unsigned A_ENA = 'h19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [NPINS-1:0] bus_wdata,
    input  logic [NPINS-1:0] edge_i,
    output logic [NPINS-1:0] pol_q,
    output logic [NPINS-1:0] flag_q,
    output logic [NPINS-1:0] ena_q,
    output logic [NPINS-1:0] bus_rdata,
    output logic             irq_o
);

    reg_sel_e         sel;
    logic [NPINS-1:0] flag_base;

    // Decode the address into a register select.
    always_comb begin
        if (bus_addr == AW'(A_POL))      sel = RSEL_POL;
        else if (bus_addr == AW'(A_FLG)) sel = RSEL_FLG;
        else if (bus_addr == AW'(A_ENA)) sel = RSEL_ENA;
        else                             sel = RSEL_NONE;
    end

    // Polarity register.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pol_q <= '0;
        else if (bus_we && sel == RSEL_POL)  pol_q <= bus_wdata;
    end

    // Flag base: the written byte on a flag write, otherwise the held flags.
    always_comb flag_base = (bus_we && sel == RSEL_FLG) ? bus_wdata : flag_q;

    // Flag register: edges set bits on top of the base.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_base | edge_i;
    end

    // Enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ena_q <= '0;
        else if (bus_we && sel == RSEL_ENA)  ena_q <= bus_wdata;
    end

    // Registered request: any enabled flag.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(flag_q & ena_q);
    end

    // Read mux; unmapped addresses return zero.
    always_comb begin
        unique case (sel)
            RSEL_POL: bus_rdata = pol_q;
            RSEL_FLG: bus_rdata = flag_q;
            RSEL_ENA: bus_rdata = ena_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pin_edge_irq.sv
// Edge-selectable pin interrupt controller, top level.
// Chain: synchronizer -> polarity edge detector -> flags, then masked OR.
// Assumes a single clock domain for the bus and a synchronous active-low reset.
module pin_edge_irq #(
    parameter int unsigned NPINS = 8,
    parameter int unsigned AW    = 9,
    parameter int unsigned A_POL = 'h17,
    parameter int unsigned A_FLG = 'h18,
    parameter int unsigned A_ENA = 'h19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    output logic             irq_o
);

    logic [NPINS-1:0] lvl;
    logic [NPINS-1:0] edge_v;
    logic [NPINS-1:0] pol_q;
    logic [NPINS-1:0] flag_q;
    logic [NPINS-1:0] ena_q;

    pei_sync #(.NPINS(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_i),
        .lvl_o (lvl)
    );

    pei_edge #(.NPINS(NPINS)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl),
        .pol_i  (pol_q),
        .edge_o (edge_v)
    );

    pei_regs #(
        .NPINS (NPINS),
        .AW    (AW),
        .A_POL (A_POL),
        .A_FLG (A_FLG),
        .A_ENA (A_ENA)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .edge_i    (edge_v),
        .pol_q     (pol_q),
        .flag_q    (flag_q),
        .ena_q     (ena_q),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

endmodule

// File: rtl/pin_edge_irq_chk.sv
// Assertion checker for pin_edge_irq, attached by bind.
module pin_edge_irq_chk #(
    parameter int unsigned NPINS = 8,
    parameter int unsigned AW    = 9,
    parameter int unsigned A_POL = 'h17,
    parameter int unsigned A_FLG = 'h18,
    parameter int unsigned A_ENA = 'h19
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    bus_addr,
    input logic             bus_we,
    input logic [NPINS-1:0] bus_rdata,
    input logic             irq_o,
    input logic [NPINS-1:0] edge_v,
    input logic [NPINS-1:0] flag_q,
    input logic [NPINS-1:0] ena_q
);

    logic unmapped;
    logic flag_wr;

    always_comb begin
        unmapped = (bus_addr != AW'(A_POL)) && (bus_addr != AW'(A_FLG)) &&
                   (bus_addr != AW'(A_ENA));
        flag_wr  = bus_we && (bus_addr == AW'(A_FLG));
    end

    // R3, R4, R7: every detected edge leaves its flag set on the next cycle.
    a_r3_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_v != '0) |=> ((flag_q & $past(edge_v)) == $past(edge_v)));

    // R6: without a flag write, no set flag drops.
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    // R8: a high request had an enabled flag one cycle earlier.
    a_r8_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((flag_q & ena_q) != '0));

    // R8: an enabled flag raises the request on the next cycle.
    a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ena_q) != '0) |=> irq_o);

    // R9: unmapped addresses read as zero.
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (bus_rdata == '0));

endmodule

bind pin_edge_irq pin_edge_irq_chk #(
    .NPINS (NPINS),
    .AW    (AW),
    .A_POL (A_POL),
    .A_FLG (A_FLG),
    .A_ENA (A_ENA)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .edge_v    (edge_v),
    .flag_q    (flag_q),
    .ena_q     (ena_q)
);

// File: tb/pin_edge_irq_test.sv
// Scoreboard bench. Driver tasks act at falling edges and queue expectations.
// The monitor compares outputs 1 time unit after each falling edge.
module pin_edge_irq_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [8:0] A_POL = 9'h017;
    localparam logic [8:0] A_FLG = 9'h018;
    localparam logic [8:0] A_ENA = 9'h019;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_i = '0;
    logic [8:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_o;

    typedef struct {
        bit         is_irq;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    pin_edge_irq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: pop one item per cycle and compare.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it  = q.pop_front();
                act = it.is_irq ? {7'd0, irq_o} : bus_rdata;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
    endtask

    task automatic chk(input logic [8:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_we   = 1'b0;
        bus_addr = a;
        it.is_irq = 1'b0;
        it.exp    = e;
        it.tag    = tag;
        q.push_back(it);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        bus_we = 1'b0;
        it.is_irq = 1'b1;
        it.exp    = {7'd0, e};
        it.tag    = tag;
        q.push_back(it);
    endtask

    task automatic set_pin(input logic [7:0] v);
        @(negedge clk);
        bus_we = 1'b0;
        pin_i  = v;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        chk(A_POL, 8'h00, "R1 polarity reset");
        chk(A_FLG, 8'h00, "R1 flag reset");
        chk(A_ENA, 8'h00, "R1 enable reset");
        chk_irq(1'b0, "R1 irq reset");

        // R9 unmapped addresses
        wr(9'h01A, 8'hFF);
        chk(9'h01A, 8'h00, "R9 unmapped read 0x01A");
        wr(9'h016, 8'hFF);
        chk(9'h016, 8'h00, "R9 unmapped read 0x016");
        chk(A_POL, 8'h00, "R9 write ignored pol");
        chk(A_FLG, 8'h00, "R9 write ignored flg");
        chk(A_ENA, 8'h00, "R9 write ignored ena");

        // R3, R4: rising edge on pin 0 with enable clear
        set_pin(8'h01);
        idle();
        chk(A_FLG, 8'h00, "R3 flag not yet set");
        chk(A_FLG, 8'h01, "R3 R4 rising flag set");
        chk_irq(1'b0, "R4 disabled flag no irq");

        // R6 clear by writing zero
        wr(A_FLG, 8'h00);
        chk(A_FLG, 8'h00, "R6 flag cleared");

        // R10 falling edge ignored while rising selected
        set_pin(8'h00);
        idle();
        idle();
        chk(A_FLG, 8'h00, "R10 falling ignored");

        // R5 polarity 0->1 on steady low pin 1 sets its flag
        wr(A_POL, 8'h02);
        chk(A_FLG, 8'h00, "R5 not yet");
        chk(A_FLG, 8'h02, "R5 polarity write edge");
        chk(A_POL, 8'h02, "R2 polarity readback");
        wr(A_FLG, 8'h00);

        // R10 rising ignored with falling selected
        set_pin(8'h02);
        idle();
        idle();
        chk(A_FLG, 8'h00, "R10 rising ignored");

        // R3 falling edge detected
        set_pin(8'h00);
        idle();
        chk(A_FLG, 8'h00, "R3 falling not yet");
        chk(A_FLG, 8'h02, "R3 falling flag set");

        // R8 enable raises the request one edge later
        wr(A_ENA, 8'h02);
        chk_irq(1'b0, "R8 irq not yet");
        chk_irq(1'b1, "R8 irq asserted");
        chk(A_ENA, 8'h02, "R2 enable readback");
        wr(A_FLG, 8'h00);
        chk_irq(1'b1, "R8 irq still high");
        chk_irq(1'b0, "R8 irq dropped");

        // R8 masked flag on pin 0 keeps the request low
        set_pin(8'h01);
        idle();
        idle();
        chk(A_FLG, 8'h01, "R4 masked flag set");
        chk_irq(1'b0, "R8 masked no irq");
        wr(A_ENA, 8'h03);
        chk_irq(1'b0, "R8 enable not yet");
        chk_irq(1'b1, "R8 enable raises irq");
        wr(A_FLG, 8'h00);
        idle();
        chk_irq(1'b0, "R8 cleared low");

        // R7 edge wins over a clearing write in the same cycle
        set_pin(8'h05);
        idle();
        wr(A_FLG, 8'h00);
        chk(A_FLG, 8'h04, "R7 edge beats clear");
        wr(A_FLG, 8'h00);

        // R6 write loads the byte directly
        wr(A_FLG, 8'hA0);
        chk(A_FLG, 8'hA0, "R6 flag load");
        wr(A_FLG, 8'h00);

        // R5 adjusted level falling: no flag; rising: flag
        wr(A_POL, 8'h06);
        idle();
        chk(A_FLG, 8'h00, "R5 adjusted fall no flag");
        wr(A_POL, 8'h02);
        idle();
        chk(A_FLG, 8'h04, "R5 adjusted rise flag");
        wr(A_FLG, 8'h00);

        // R3 several pins together, pin 1 on falling stays clear
        set_pin(8'hFF);
        idle();
        idle();
        chk(A_FLG, 8'hF8, "R3 multi-pin rising");

        idle();
        idle();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule